// File: doc/BRIEF.md
# Constant-Divisor Reciprocal Divider

This block divides an unsigned W-bit dividend by a divisor that is fixed when the design is elaborated. It does not run an iterative divide. A constant function works out, at elaboration, a fixed-point reciprocal of the divisor, a post-shift and which of four datapath variants to build. At run time each dividend goes through a registered high-half multiply, then a correction and shift stage, then an output register.

The four variants are as follows. A power-of-two divisor becomes a plain right shift. A divisor above half the dividend range becomes a single compare. A divisor whose reciprocal fits in W bits takes the upper half of the product and shifts it. A divisor whose reciprocal needs W+1 bits, such as 7, uses only the low W bits of the reciprocal and recovers the missing bit with a subtract, halve and add step that cannot overflow.

A dividend is offered with `in_valid`. Its quotient, and its remainder if that is enabled, appear with `out_valid` three clock edges later. The block accepts a new dividend on every cycle.

Top module: `const_recip_div`

## Requirements
- R1: When the reciprocal fits in W bits (for example divisor 5 or 3 at W=64), the quotient equals floor(n / d) for every dividend n from 0 to 2^W-1.
- R2: When the reciprocal needs W+1 bits (for example divisor 7), the quotient equals floor(n / d) for every dividend, including 2^W-1, and the internal correction step never subtracts a larger value from a smaller one.
- R3: For a divisor 2^k (including d = 1, where k = 0), the quotient equals n shifted right by k bits.
- R4: For a divisor above 2^(W-1), the quotient is 1 when n >= d and 0 otherwise.
- R5: A dividend accepted with in_valid high at rising edge t gives out_valid high after edge t+2, with its own result. A cycle with in_valid low gives out_valid low three edges later. Back-to-back dividends give back-to-back results in the same order.
- R6: With HAS_REM = 1, out_remainder equals n - q*d, which is always below d. With HAS_REM = 0, out_remainder reads 0.
- R7: While rst is high, and after any rising edge at which rst was high, out_valid, out_quotient and out_remainder are 0. Dividends that are in flight when reset arrives produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Dividend present this cycle |
| in_dividend | input | W | Unsigned dividend |
| out_valid | output | 1 | Result present this cycle |
| out_quotient | output | W | floor(dividend / DIVISOR) |
| out_remainder | output | W | dividend mod DIVISOR, or 0 when HAS_REM = 0 |

## Verification
Six copies of the block, with divisors 7, 5, 8, 1, 2^63+3 and 3, all receive the same dividend stream. This exercises every variant under identical inputs. The stream starts with small values and values around each divisor (d-1, d, d+1). Those values separate an exact quotient from one that is off by one at a rounding boundary. It continues with 2^W-1 and 2^W-2, which are the dividends where too short a reciprocal or an overflowing correction first gives a wrong answer, and with multiples of 7, 5 and 3 plus or minus one, which probe each step where the quotient changes. Random 64-bit dividends with random idle gaps, and a reset that arrives while dividends are still in the pipeline, check the latency and ordering of valid and that reset flushes the pipeline.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  // Datapath variant chosen at elaboration from the divisor value.
  typedef enum logic [1:0] {
    CDIV_SHIFT  = 2'd0,  // divisor is a power of two
    CDIV_CMP    = 2'd1,  // divisor above half of the dividend range
    CDIV_MUL    = 2'd2,  // reciprocal fits in W bits
    CDIV_MULFIX = 2'd3   // reciprocal needs W+1 bits, corrected product
  } cdiv_mode_e;

endpackage

// File: rtl/cdiv_mul_stage.sv
module cdiv_mul_stage #(
  parameter int           W       = 64,
  parameter logic [W-1:0] MAGIC   = '0,
  parameter bit           USE_MUL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_n,
  output logic         s2_v,
  output logic [W-1:0] s2_n,
  output logic [W-1:0] s2_hi
);

  localparam int PW = 2 * W;

  logic         s1_v;
  logic [W-1:0] s1_n;
  logic [W-1:0] hi_next;

  // Stage 1: capture the dividend.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_n <= '0;
    end else begin
      s1_v <= in_v;
      s1_n <= in_v ? in_n : '0;
    end
  end

  // Upper half of dividend times reciprocal, only where a variant needs it.
  generate
    if (USE_MUL) begin : g_mul
      always_comb begin
        hi_next = W'(({{W{1'b0}}, s1_n} * {{W{1'b0}}, MAGIC}) >> W);
      end
    end else begin : g_nomul
      always_comb begin
        hi_next = '0;
      end
    end
  endgenerate

  // Stage 2: register the high product together with the dividend.
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v  <= 1'b0;
      s2_n  <= '0;
      s2_hi <= '0;
    end else begin
      s2_v  <= s1_v;
      s2_n  <= s1_n;
      s2_hi <= hi_next;
    end
  end

  // R2: the high half never exceeds the dividend (reciprocal below one).
  hi_le_dividend_chk: assert property (@(posedge clk) disable iff (rst)
    s2_v |-> (s2_hi <= s2_n))
    else $error("high product exceeds dividend");

  localparam int UNUSED_PW = PW;

endmodule

// File: rtl/cdiv_fix_stage.sv
module cdiv_fix_stage
  import cdiv_pkg::*;
#(
  parameter int           W       = 64,
  parameter logic [W-1:0] DIVISOR = 7,
  parameter cdiv_mode_e   MODE    = CDIV_MUL,
  parameter int           POST    = 0,
  parameter bit           HAS_REM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_v,
  input  logic [W-1:0] s_n,
  input  logic [W-1:0] s_hi,
  output logic         out_v,
  output logic [W-1:0] out_q,
  output logic [W-1:0] out_r
);

  localparam int FIXSH = (POST > 0) ? POST - 1 : 0;

  logic [W-1:0] q_next;
  logic [W-1:0] r_next;
  logic [W-1:0] half_gap;

  always_comb begin
    // Subtract-then-halve keeps the sum inside W bits.
    half_gap = (s_n - s_hi) >> 1;
    unique case (MODE)
      CDIV_SHIFT:  q_next = s_n >> POST;
      CDIV_CMP:    q_next = (s_n >= DIVISOR) ? W'(1) : '0;
      CDIV_MUL:    q_next = s_hi >> POST;
      CDIV_MULFIX: q_next = (s_hi + half_gap) >> FIXSH;
      default:     q_next = '0;
    endcase
  end

  generate
    if (HAS_REM) begin : g_rem
      always_comb begin
        r_next = s_n - W'(q_next * DIVISOR);
      end
    end else begin : g_norem
      always_comb begin
        r_next = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      out_q <= '0;
      out_r <= '0;
    end else begin
      out_v <= s_v;
      out_q <= s_v ? q_next : '0;
      out_r <= s_v ? r_next : '0;
    end
  end

  // Wide products used only by the checks below.
  logic [2*W-1:0] qd_wide;
  logic [2*W-1:0] n_wide;
  logic [2*W-1:0] d_wide;
  always_comb begin
    qd_wide = {{W{1'b0}}, q_next} * {{W{1'b0}}, DIVISOR};
    n_wide  = {{W{1'b0}}, s_n};
    d_wide  = {{W{1'b0}}, DIVISOR};
  end

  // R1
  exact_quot_chk: assert property (@(posedge clk) disable iff (rst)
    s_v |-> ((qd_wide <= n_wide) && ((n_wide - qd_wide) < d_wide)))
    else $error("quotient not exact");

  // R4
  cmp_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_v && (MODE == CDIV_CMP)) |-> (out_q <= W'(1)))
    else $error("compare variant out of range");

  // R6
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (out_v && HAS_REM) |-> (out_r < DIVISOR))
    else $error("remainder not below divisor");

endmodule

// File: rtl/const_recip_div.sv
module const_recip_div
  import cdiv_pkg::*;
#(
  parameter int           W       = 64,
  parameter logic [W-1:0] DIVISOR = 7,
  parameter bit           HAS_REM = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_dividend,
  output logic         out_valid,
  output logic [W-1:0] out_quotient,
  output logic [W-1:0] out_remainder
);

  localparam int XW     = 2 * W + 2;
  localparam int LOGD   = $clog2(DIVISOR);
  localparam bit IS_POW2 = ((DIVISOR & (DIVISOR - W'(1))) == '0);
  localparam bit IS_BIG  = (DIVISOR > (W'(1) << (W - 1)));

  // Reciprocal search: start from ceil(log2 d) and drop shift bits while
  // the low and high bounds still differ after halving.
  function automatic logic [XW-1:0] recip_search(input bit want_shift);
    logic [XW-1:0] lo;
    logic [XW-1:0] hi;
    int            sh;
    lo = (XW'(1) << (W + LOGD)) / XW'(DIVISOR);
    hi = ((XW'(1) << (W + LOGD)) + (XW'(1) << LOGD)) / XW'(DIVISOR);
    sh = LOGD;
    while (((lo >> 1) < (hi >> 1)) && (sh > 0)) begin
      lo = lo >> 1;
      hi = hi >> 1;
      sh = sh - 1;
    end
    return want_shift ? XW'(unsigned'(sh)) : hi;
  endfunction

  localparam logic [XW-1:0] M_FULL  = recip_search(1'b0);
  localparam logic [XW-1:0] M_SHIFT = recip_search(1'b1);

  localparam cdiv_mode_e MODE =
    IS_POW2 ? CDIV_SHIFT :
    IS_BIG  ? CDIV_CMP   :
    (M_FULL >= (XW'(1) << W)) ? CDIV_MULFIX : CDIV_MUL;

  localparam int POST = IS_POW2 ? LOGD : (IS_BIG ? 0 : int'(M_SHIFT[15:0]));
  localparam bit USE_MUL = (MODE == CDIV_MUL) || (MODE == CDIV_MULFIX);
  localparam logic [W-1:0] MAGIC = USE_MUL ? M_FULL[W-1:0] : '0;

  logic         s2_v;
  logic [W-1:0] s2_n;
  logic [W-1:0] s2_hi;

  cdiv_mul_stage #(
    .W      (W),
    .MAGIC  (MAGIC),
    .USE_MUL(USE_MUL)
  ) u_mul (
    .clk  (clk),
    .rst  (rst),
    .in_v (in_valid),
    .in_n (in_dividend),
    .s2_v (s2_v),
    .s2_n (s2_n),
    .s2_hi(s2_hi)
  );

  cdiv_fix_stage #(
    .W      (W),
    .DIVISOR(DIVISOR),
    .MODE   (MODE),
    .POST   (POST),
    .HAS_REM(HAS_REM)
  ) u_fix (
    .clk  (clk),
    .rst  (rst),
    .s_v  (s2_v),
    .s_n  (s2_n),
    .s_hi (s2_hi),
    .out_v(out_valid),
    .out_q(out_quotient),
    .out_r(out_remainder)
  );

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3))
    else $error("result without a dividend three edges earlier");

endmodule

// File: tb/const_recip_div_test.sv
module const_recip_div_test;

  localparam int NI = 6;
  localparam logic [63:0] BIG = 64'h8000_0000_0000_0003;
  localparam logic [63:0] DV [NI] = '{64'd7, 64'd5, 64'd8, 64'd1, BIG, 64'd3};
  localparam bit          RE [NI] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_dividend = '0;

  logic        ov [NI];
  logic [63:0] oq [NI];
  logic [63:0] orr[NI];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < NI; g++) begin : gen_dut
    const_recip_div #(
      .W      (64),
      .DIVISOR(DV[g]),
      .HAS_REM(RE[g])
    ) uut (
      .clk          (clk),
      .rst          (rst),
      .in_valid     (in_valid),
      .in_dividend  (in_dividend),
      .out_valid    (ov[g]),
      .out_quotient (oq[g]),
      .out_remainder(orr[g])
    );
  end

  // Reference model: one history entry per rising edge.
  bit          hv[$];
  logic [63:0] hn[$];

  always @(posedge clk) begin
    if (rst) begin
      // R7: reset at this edge flushes the two older entries still in flight.
      if (hv.size() >= 1) hv[hv.size()-1] = 1'b0;
      if (hv.size() >= 2) hv[hv.size()-2] = 1'b0;
      hv.push_back(1'b0);
    end else begin
      hv.push_back(in_valid);
    end
    hn.push_back(in_dividend);
  end

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";
      1: return "R1";
      2: return "R3";
      3: return "R3";
      4: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NI; i++) begin
        check64("R7", "valid in reset", 64'(ov[i]), 64'd0);
        check64("R7", "quotient in reset", oq[i], 64'd0);
      end
    end else if (hv.size() >= 3) begin
      bit          ev;
      logic [63:0] en;
      ev = hv[hv.size()-3];
      en = hn[hn.size()-3];
      for (int i = 0; i < NI; i++) begin
        check64("R5", "valid", 64'(ov[i]), 64'(ev));
        if (ev) begin
          check64(tag_of(i), "quotient", oq[i], en / DV[i]);
          check64("R6", "remainder", orr[i], RE[i] ? (en % DV[i]) : 64'd0);
        end
      end
    end
  end

  task automatic send(logic [63:0] n);
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = n;
  endtask

  task automatic idle(int k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      in_valid    = 1'b0;
      in_dividend = '0;
    end
  endtask

  initial begin
    // R7: reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(3);

    // R1 R2 R3 R4: small values and the neighbourhood of each divisor
    for (int v = 0; v < 20; v++) send(64'(v));
    send(64'hFFFF_FFFF_FFFF_FFFF);
    send(64'hFFFF_FFFF_FFFF_FFFE);
    send(BIG - 1);
    send(BIG);
    send(BIG + 1);
    send(64'h8000_0000_0000_0000);
    idle(2);

    // Multiples of 7, 5 and 3 plus or minus one
    for (int j = 0; j < 40; j++) begin
      logic [63:0] k;
      k = {$urandom, $urandom} >> (j % 60 + 3);
      send(k * 7 - 1); send(k * 7); send(k * 7 + 1);
      send(k * 5 - 1); send(k * 5); send(k * 5 + 1);
      send(k * 3 - 1); send(k * 3); send(k * 3 + 1);
    end
    send(64'd9362914084632502025 * 64'd1);
    send(64'h2492_4924_9249_2492 * 64'd7);

    // R5: random dividends with random gaps
    for (int j = 0; j < 3000; j++) begin
      send({$urandom, $urandom});
      if (($urandom % 5) == 0) idle(1 + $urandom % 3);
    end

    // R7: reset while results are in flight
    send(64'd1000); send(64'd2000);
    @(negedge clk);
    in_valid = 1'b1;
    in_dividend = 64'd3000;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    send(64'd49); send(64'd50);
    idle(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule